// File: doc/BRIEF.md
# Command Ring Queue Controller

This block is the control and status unit of a single host command ring that feeds a pool of execution engines. Software programs the ring through a small register port. It sets the ring base address, the ring length in commands, a starting slot offset and a completion threshold. It then posts work by writing a count of new commands to a doorbell register.

Whenever the queue is enabled and the doorbell holds unread commands, the block presents a fetch request carrying the host address of the next 32-byte command. Each accepted fetch advances the slot offset and becomes one in-flight command. Engines report finished commands on a completion strobe, which adds to a completed-command count. When that count reaches the threshold, the block raises a one-cycle interrupt pulse.

Software acknowledges completions by writing back the count it read. A separate bit lets software ask for the interrupt again. Disabling the queue stops new fetches at once. The activity flag stays high until every in-flight command has completed, so software can poll for quiescence before it reprograms the ring.

Top module: `cmd_ring_ctrl`

## Requirements
- R1: After reset every register reads zero, `fetch_req` is 0 and `cmpl_irq` is 0.
- R2: Register port, write index 2 (doorbell): the value in bits 31:0 is added to the pending count. The value 0xFFFFFFFF instead clears the pending count to zero. A read of index 2 returns the pending count.
- R3: Each fetch accepted (`fetch_req` and `fetch_ack` high together) lowers the pending count by one. A doorbell write in the same cycle nets with the fetch, for example 3 + 2 - 1 = 4.
- R4: `fetch_addr` equals the base (index 3) plus the slot offset (index 5). A base write keeps bits 63:5 and forces bits 4:0 to zero.
- R5: The slot offset advances by 32 on each accepted fetch. When the slot number plus one reaches the ring size (index 4), the offset wraps to 0, so a size of 0 or 1 always wraps. A write to index 5 sets the offset, with bits 4:0 dropped.
- R6: Bit 0 of the activity register (index 1) reads 1 while the queue is enabled or any fetched command is still outstanding. Otherwise it reads 0. Each accepted fetch adds one outstanding command and each `cmd_done` pulse removes one.
- R7: The completion register (index 7) reads the completed count in bits 31:0. Bit 32 is the status flag: 1 when the threshold (index 6) is nonzero and the count is at or above it. Bits 63:33 read zero. Each `cmd_done` pulse adds one to the count.
- R8: A write to index 7 subtracts its bits 31:0 from the count, so writing back the value just read clears it. A `cmd_done` pulse in the same cycle still counts.
- R9: `cmpl_irq` pulses high for one cycle in the cycle in which the status flag rises.
- R10: A write to index 7 with bit 33 set pulses `cmpl_irq` for one cycle if the status flag is still 1 after that write. If the flag is 0, no pulse follows.
- R11: Bit 0 of index 0 enables the queue. While it is 0, `fetch_req` stays low and the pending count is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write index |
| reg_wdata | input | 64 | Register write data |
| reg_raddr | input | 3 | Register read index |
| reg_rdata | output | 64 | Register read data (combinational) |
| fetch_req | output | 1 | A command is ready to be fetched |
| fetch_addr | output | ADDR_W | Host address of the next command |
| fetch_ack | input | 1 | The fetch is accepted this cycle |
| cmd_done | input | 1 | One command has completed |
| cmpl_irq | output | 1 | One-cycle completion interrupt pulse |

## Verification
Two pairs of events can coincide in one cycle, and the bench forces both deliberately.

In the first pair, a doorbell write lands in the same cycle as an accepted fetch. The bench drives both strobes from one falling edge and expects the pending count to equal the sum minus one.

In the second pair, a write-back of the completion count meets a `cmd_done` pulse. The bench expects the count to be left unchanged.

Sweeps over ring sizes 1 to 4 compare every fetch address with base plus 32 times the slot number modulo the size. They also count interrupt pulses while the queue drains after it has been disabled.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int unsigned CNT_W     = 32;
  localparam int unsigned REG_W     = 64;
  localparam int unsigned CMD_SHIFT = 5;   // 32-byte commands

  typedef enum logic [2:0] {
    CQ_ENABLE = 3'd0,
    CQ_ACTIVE = 3'd1,
    CQ_DBELL  = 3'd2,
    CQ_BASE   = 3'd3,
    CQ_SIZE   = 3'd4,
    CQ_NEXT   = 3'd5,
    CQ_THRESH = 3'd6,
    CQ_COMPL  = 3'd7
  } cq_reg_e;
endpackage

// File: rtl/cq_doorbell.sv
module cq_doorbell
  import cq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_nx;

  always_comb begin
    count_nx = count - CNT_W'(dec);
    if (wr) begin
      if (&wdata) count_nx = '0;
      else        count_nx = count + wdata - CNT_W'(dec);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (wr || dec) count <= count_nx;
  end
endmodule

// File: rtl/cq_ring_ptr.sv
module cq_ring_ptr
  import cq_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [CNT_W-1:0]  size,
  input  logic              adv,
  output logic [ADDR_W-1:0] offset
);
  localparam int unsigned SLOT_W = ADDR_W - CMD_SHIFT;

  logic [ADDR_W:0]   slot_inc;
  logic [ADDR_W:0]   size_ext;
  logic [ADDR_W-1:0] offset_nx;

  assign slot_inc = (ADDR_W+1)'(offset[ADDR_W-1:CMD_SHIFT]) + (ADDR_W+1)'(1);
  assign size_ext = (ADDR_W+1)'(size);

  always_comb begin
    if (wr)
      offset_nx = {wdata[ADDR_W-1:CMD_SHIFT], CMD_SHIFT'(0)};
    else if (slot_inc >= size_ext)
      offset_nx = '0;
    else
      offset_nx = {slot_inc[SLOT_W-1:0], CMD_SHIFT'(0)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) offset <= '0;
    else if (wr || adv) offset <= offset_nx;
  end
endmodule

// File: rtl/cq_completion.sv
module cq_completion
  import cq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             resend,
  input  logic [CNT_W-1:0] thresh,
  output logic [CNT_W-1:0] count,
  output logic             status,
  output logic             irq
);
  logic [CNT_W-1:0] count_nx;
  logic             status_nx;
  logic             irq_nx;

  always_comb begin
    count_nx  = count + CNT_W'(done) - (wr ? wdata : '0);
    status_nx = (thresh != '0) && (count_nx >= thresh);
    irq_nx    = (status_nx && !status) || (wr && resend && status_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      status <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr || done) count <= count_nx;
      status <= status_nx;
      irq    <= irq_nx;
    end
  end
endmodule

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl
  import cq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned FLIGHT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_waddr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [2:0]        reg_raddr,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  input  logic              cmd_done,
  output logic              cmpl_irq
);
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic wr_en, wr_dbell, wr_base, wr_size, wr_next, wr_thr, wr_cmpl;
  always_comb begin
    wr_en    = reg_we && (cq_reg_e'(reg_waddr) == CQ_ENABLE);
    wr_dbell = reg_we && (cq_reg_e'(reg_waddr) == CQ_DBELL);
    wr_base  = reg_we && (cq_reg_e'(reg_waddr) == CQ_BASE);
    wr_size  = reg_we && (cq_reg_e'(reg_waddr) == CQ_SIZE);
    wr_next  = reg_we && (cq_reg_e'(reg_waddr) == CQ_NEXT);
    wr_thr   = reg_we && (cq_reg_e'(reg_waddr) == CQ_THRESH);
    wr_cmpl  = reg_we && (cq_reg_e'(reg_waddr) == CQ_COMPL);
  end

  logic              en_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  size_q, thr_q;
  logic [FLIGHT_W-1:0] flight_q, flight_nx;
  logic [CNT_W-1:0]  dbell;
  logic [ADDR_W-1:0] offset;
  logic [CNT_W-1:0]  cmpl_cnt;
  logic              cmpl_status;
  logic              accept, active;

  assign accept    = fetch_req && fetch_ack;
  assign fetch_req = en_q && (dbell != '0);
  assign fetch_addr = base_q + offset;
  assign active    = en_q || (flight_q != '0);
  assign flight_nx = flight_q + FLIGHT_W'(accept) - FLIGHT_W'(cmd_done);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q     <= 1'b0;
      base_q   <= '0;
      size_q   <= '0;
      thr_q    <= '0;
      flight_q <= '0;
    end else begin
      if (wr_en)   en_q   <= reg_wdata[0];
      if (wr_base) base_q <= {reg_wdata[ADDR_W-1:CMD_SHIFT], CMD_SHIFT'(0)};
      if (wr_size) size_q <= reg_wdata[CNT_W-1:0];
      if (wr_thr)  thr_q  <= reg_wdata[CNT_W-1:0];
      if (accept || cmd_done) flight_q <= flight_nx;
    end
  end

  cq_doorbell u_dbell (
    .clk(clk), .rst_n(rst_sync_n), .wr(wr_dbell),
    .wdata(reg_wdata[CNT_W-1:0]), .dec(accept), .count(dbell)
  );

  cq_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n), .wr(wr_next),
    .wdata(reg_wdata[ADDR_W-1:0]), .size(size_q), .adv(accept), .offset(offset)
  );

  cq_completion u_cmpl (
    .clk(clk), .rst_n(rst_sync_n), .done(cmd_done), .wr(wr_cmpl),
    .wdata(reg_wdata[CNT_W-1:0]), .resend(reg_wdata[CNT_W+1]),
    .thresh(thr_q), .count(cmpl_cnt), .status(cmpl_status), .irq(cmpl_irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (cq_reg_e'(reg_raddr))
      CQ_ENABLE: reg_rdata = REG_W'(en_q);
      CQ_ACTIVE: reg_rdata = REG_W'(active);
      CQ_DBELL:  reg_rdata = REG_W'(dbell);
      CQ_BASE:   reg_rdata = REG_W'(base_q);
      CQ_SIZE:   reg_rdata = REG_W'(size_q);
      CQ_NEXT:   reg_rdata = REG_W'(offset);
      CQ_THRESH: reg_rdata = REG_W'(thr_q);
      CQ_COMPL:  reg_rdata = REG_W'(cmpl_cnt) | (REG_W'(cmpl_status) << CNT_W);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmd_ring_ctrl_chk.sv
module cmd_ring_ctrl_chk
  import cq_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic              fetch_ack,
  input logic              active,
  input logic              dbell_wr,
  input logic [CNT_W-1:0]  dbell,
  input logic              next_wr,
  input logic [ADDR_W-1:0] offset,
  input logic              status,
  input logic              irq
);
  // R3: an accepted fetch with no doorbell write lowers the count by one
  p_dbell_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack && !dbell_wr) |=> (dbell == $past(dbell) - 1));

  // R5: the offset holds unless a fetch is accepted or it is written
  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fetch_req && fetch_ack) && !next_wr) |=> $stable(offset));

  // R5: the offset always points to a command boundary
  p_ptr_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    offset[CMD_SHIFT-1:0] == '0);

  // R6: a quiescent queue never requests a fetch
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !fetch_req);

  // R9: an interrupt pulse only accompanies a set status flag
  p_irq_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status);

  // R9: a rising status flag is always signalled
  p_rise_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> irq);
endmodule

bind cmd_ring_ctrl cmd_ring_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
  .active(active), .dbell_wr(wr_dbell), .dbell(dbell), .next_wr(wr_next),
  .offset(offset), .status(cmpl_status), .irq(cmpl_irq)
);

// File: tb/cmd_ring_ctrl_test.sv
module cmd_ring_ctrl_test;
  localparam int ADDR_W = 64;
  localparam logic [2:0] A_EN = 3'd0, A_ACT = 3'd1, A_DB = 3'd2, A_BASE = 3'd3,
                         A_SIZE = 3'd4, A_NEXT = 3'd5, A_THR = 3'd6, A_CMPL = 3'd7;

  logic clk, rst_n, reg_we, fetch_ack, cmd_done;
  logic [2:0] reg_waddr, reg_raddr;
  logic [63:0] reg_wdata, reg_rdata;
  logic fetch_req, cmpl_irq;
  logic [ADDR_W-1:0] fetch_addr;
  int checks = 0, fails = 0;

  cmd_ring_ctrl #(.ADDR_W(ADDR_W), .FLIGHT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .cmd_done(cmd_done), .cmpl_irq(cmpl_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [63:0] d);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] v;
    int pulses;
    rst_n = 1'b0; reg_we = 1'b0; reg_waddr = '0; reg_wdata = '0; reg_raddr = '0;
    fetch_ack = 1'b0; cmd_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 64'd0);
    end
    chk("R1 fetch_req", 64'(fetch_req), 64'd0);
    chk("R1 irq", 64'(cmpl_irq), 64'd0);

    for (int s = 1; s <= 4; s++) begin
      int n;
      logic [63:0] b;
      n = 2 * s + 1;
      b = 64'h1000 * s + 64'h40;
      reg_wr(A_EN, 0);
      reg_wr(A_DB, 64'hFFFF_FFFF);
      reg_wr(A_NEXT, 0);
      reg_wr(A_BASE, b);
      reg_wr(A_SIZE, 64'(s));
      reg_wr(A_THR, 64'(s));
      reg_wr(A_DB, 64'(n));
      rd(A_DB, v);
      chk("R2 doorbell add", v, 64'(n));
      chk("R11 no fetch while disabled", 64'(fetch_req), 64'd0);
      reg_wr(A_EN, 1);
      for (int k = 0; k < n; k++) begin
        chk("R3 fetch_req", 64'(fetch_req), 64'd1);
        chk("R4 R5 fetch_addr", fetch_addr, b + 64'((k % s) * 32));
        fetch_ack = 1'b1;
        @(negedge clk);
        fetch_ack = 1'b0;
        #1;
      end
      rd(A_DB, v);
      chk("R3 doorbell drained", v, 64'd0);
      chk("R3 fetch_req low", 64'(fetch_req), 64'd0);
      rd(A_NEXT, v);
      chk("R5 offset wrap", v, 64'((n % s) * 32));
      reg_wr(A_EN, 0);
      rd(A_ACT, v);
      chk("R6 active after disable", v, 64'd1);
      pulses = 0;
      for (int j = 0; j < n; j++) begin
        cmd_done = 1'b1;
        @(negedge clk);
        #1;
        if (cmpl_irq) pulses++;
      end
      cmd_done = 1'b0;
      @(negedge clk); #1;
      if (cmpl_irq) pulses++;
      chk("R9 pulse count", 64'(pulses), 64'd1);
      rd(A_ACT, v);
      chk("R6 quiescent", v, 64'd0);
      rd(A_CMPL, v);
      chk("R7 completion reg", v, 64'(n) | (64'd1 << 32));
      reg_wr(A_CMPL, 64'd1 << 33);
      chk("R10 resend pulse", 64'(cmpl_irq), 64'd1);
      rd(A_CMPL, v);
      reg_wr(A_CMPL, v);
      rd(A_CMPL, v);
      chk("R8 write-back clear", v, 64'd0);
      reg_wr(A_CMPL, 64'd1 << 33);
      chk("R10 no resend below threshold", 64'(cmpl_irq), 64'd0);
    end

    // R3: doorbell write coinciding with an accepted fetch
    reg_wr(A_THR, 64'd0);
    reg_wr(A_DB, 64'd3);
    reg_wr(A_EN, 1);
    fetch_ack = 1'b1; reg_we = 1'b1; reg_waddr = A_DB; reg_wdata = 64'd2;
    @(negedge clk);
    fetch_ack = 1'b0; reg_we = 1'b0;
    rd(A_DB, v);
    chk("R3 concurrent doorbell", v, 64'd4);
    reg_wr(A_EN, 0);

    // R8: write-back coinciding with a completion
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b1; reg_we = 1'b1; reg_waddr = A_CMPL; reg_wdata = 64'd1;
    @(negedge clk);
    cmd_done = 1'b0; reg_we = 1'b0;
    rd(A_CMPL, v);
    chk("R8 concurrent done", v, 64'd1);
    chk("R7 status off with zero threshold", v >> 32, 64'd0);

    // R4: base alignment
    reg_wr(A_BASE, 64'h1007F);
    rd(A_BASE, v);
    chk("R4 base aligned", v, 64'h10060);

    // R2: all-ones clear
    reg_wr(A_DB, 64'hFFFF_FFFF);
    rd(A_DB, v);
    chk("R2 all-ones clears", v, 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule